// File: doc/BRIEF.md
# Speech Burst Noise Monitor

The block watches one audio channel's envelope and decides whether the channel carries speech or only steady background noise. On every enabled sample tick it takes an unsigned envelope word from an upstream level detector and keeps a running noise-floor estimate. The estimate climbs slowly when the envelope sits above it and drops quickly when the envelope sits below it. Steady noise, or any level that drifts slowly, is therefore absorbed into the floor. A speech burst rises faster than the floor can follow, and that gap is what the block reports.

Speech is declared only when the envelope beats the updated floor by a fixed ratio of 203/128 (about 1.585, roughly 4 dB). No absolute level threshold is used. The chip uses two copies of the block. One is fed by the line-side receive envelope and the other by the microphone-side transmit envelope. Both upstream detectors should share the same decay rate so the two flags can be compared.

The rise shift is a parameter. With the default of 14 and a tick rate near 3.5 kHz, the rise time constant is about 4.7 s. The fall shift is much smaller. When it is 0, the floor takes the envelope value directly.

Top module: `nm_burst_monitor`

## Requirements
- R1: While reset is asserted, the floor output is 0 and the speech flag is 0. On the first enabled tick after reset, the floor takes the envelope value and the speech flag stays 0.
- R2: On a clock edge with the tick enable low, neither the floor nor the speech flag changes, whatever the envelope does.
- R3: On a later tick with envelope above floor, the floor rises by (envelope − floor) >> K_RISE. If that shift gives 0, it rises by exactly 1 instead.
- R4: On a later tick with envelope below floor, the floor falls by (floor − envelope) >> K_FALL. If that shift gives 0, it falls by exactly 1 instead. With K_FALL = 0, the floor takes the envelope value.
- R5: On a later tick with envelope equal to the floor, the floor does not change.
- R6: On each tick after the first, the registered speech flag becomes 1 exactly when envelope × 128 > new_floor × 203, where new_floor is the floor after that tick's update.
- R7: An envelope that rises by at most one step per tick, starting from the loaded floor, never sets the speech flag.
- R8: A jump from a settled floor to a level well above 203/128 of it sets the speech flag on that tick.
- R9: The floor always moves toward the envelope and never steps past it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample tick enable |
| env_i | input | ENV_W | Unsigned envelope level |
| speech_o | output | 1 | Registered speech flag |
| floor_o | output | ENV_W | Noise floor estimate |

## Verification
The main sweep runs on an 8-bit configuration with rise shift 4 and fall shift 1. It covers every envelope value against sixteen loaded floor levels. This separates the rise, fall and hold branches. It also exposes the minimum-step rule near the floor and tests the ratio comparison on both sides of its boundary. A unit-step ramp from zero shows that slow drift is absorbed without a flag. A jump from a settled floor shows that a burst is flagged. Tick-less cycles with a changing envelope show that nothing moves between ticks.

// File: rtl/nm_pkg.sv
package nm_pkg;
    // Default rise/fall shifts and margin ratio (MARGIN_NUM / 2**MARGIN_FRAC)
    localparam int unsigned DEF_ENV_W       = 16;
    localparam int unsigned DEF_K_RISE      = 14;
    localparam int unsigned DEF_K_FALL      = 2;
    localparam int unsigned DEF_MARGIN_NUM  = 203;
    localparam int unsigned DEF_MARGIN_FRAC = 7;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_RISE = 2'd1,
        DIR_FALL = 2'd2
    } nm_dir_e;
endpackage

// File: rtl/nm_floor_step.sv
module nm_floor_step #(
    parameter int unsigned ENV_W  = 16,
    parameter int unsigned K_RISE = 14,
    parameter int unsigned K_FALL = 2
) (
    input  logic [ENV_W-1:0] floor_i,
    input  logic [ENV_W-1:0] env_i,
    output logic [ENV_W-1:0] floor_o,
    output nm_pkg::nm_dir_e  dir_o
);
    localparam logic [ENV_W-1:0] ONE = {{(ENV_W-1){1'b0}}, 1'b1};

    logic [ENV_W-1:0] up_gap, down_gap, up_step, down_step, up_sh, down_sh;

    always_comb begin
        up_gap   = env_i - floor_i;
        down_gap = floor_i - env_i;
        up_sh    = up_gap >> K_RISE;
        up_step  = (up_sh == '0) ? ONE : up_sh;
    end

    generate
        if (K_FALL == 0) begin : g_direct_fall
            always_comb begin
                down_sh   = down_gap;
                down_step = down_gap;
            end
        end else begin : g_shift_fall
            always_comb begin
                down_sh   = down_gap >> K_FALL;
                down_step = (down_sh == '0) ? ONE : down_sh;
            end
        end
    endgenerate

    always_comb begin
        if (env_i > floor_i) begin
            dir_o   = nm_pkg::DIR_RISE;
            floor_o = floor_i + up_step;
        end else if (env_i < floor_i) begin
            dir_o   = nm_pkg::DIR_FALL;
            floor_o = floor_i - down_step;
        end else begin
            dir_o   = nm_pkg::DIR_HOLD;
            floor_o = floor_i;
        end
    end
endmodule

// File: rtl/nm_margin_cmp.sv
module nm_margin_cmp #(
    parameter int unsigned ENV_W       = 16,
    parameter int unsigned MARGIN_NUM  = 203,
    parameter int unsigned MARGIN_FRAC = 7
) (
    input  logic [ENV_W-1:0] env_i,
    input  logic [ENV_W-1:0] floor_i,
    output logic             above_o
);
    localparam int unsigned NUM_W  = $clog2(MARGIN_NUM + 1);
    localparam int unsigned PROD_W = ENV_W + ((NUM_W > MARGIN_FRAC) ? NUM_W : MARGIN_FRAC) + 1;
    localparam logic [PROD_W-1:0] NUM = PROD_W'(MARGIN_NUM);

    logic [PROD_W-1:0] env_scaled, floor_scaled;

    always_comb begin
        env_scaled   = PROD_W'(env_i) << MARGIN_FRAC;
        floor_scaled = PROD_W'(floor_i) * NUM;
        above_o      = env_scaled > floor_scaled;
    end
endmodule

// File: rtl/nm_burst_monitor.sv
module nm_burst_monitor #(
    parameter int unsigned ENV_W       = nm_pkg::DEF_ENV_W,
    parameter int unsigned K_RISE      = nm_pkg::DEF_K_RISE,
    parameter int unsigned K_FALL      = nm_pkg::DEF_K_FALL,
    parameter int unsigned MARGIN_NUM  = nm_pkg::DEF_MARGIN_NUM,
    parameter int unsigned MARGIN_FRAC = nm_pkg::DEF_MARGIN_FRAC
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [ENV_W-1:0] env_i,
    output logic             speech_o,
    output logic [ENV_W-1:0] floor_o
);
    typedef struct packed {
        logic             primed;
        logic             speech;
        logic [ENV_W-1:0] floor;
    } state_t;

    state_t           state_d, state_q;
    logic [ENV_W-1:0] step_floor;
    nm_pkg::nm_dir_e  step_dir;
    logic             above;

    nm_floor_step #(
        .ENV_W (ENV_W),
        .K_RISE(K_RISE),
        .K_FALL(K_FALL)
    ) i_step (
        .floor_i(state_q.floor),
        .env_i  (env_i),
        .floor_o(step_floor),
        .dir_o  (step_dir)
    );

    nm_margin_cmp #(
        .ENV_W      (ENV_W),
        .MARGIN_NUM (MARGIN_NUM),
        .MARGIN_FRAC(MARGIN_FRAC)
    ) i_cmp (
        .env_i  (env_i),
        .floor_i(step_floor),
        .above_o(above)
    );

    always_comb begin
        state_d = state_q;
        if (tick_i) begin
            if (!state_q.primed) begin
                // first sample after reset seeds the floor
                state_d.primed = 1'b1;
                state_d.floor  = env_i;
                state_d.speech = 1'b0;
            end else begin
                state_d.floor  = step_floor;
                state_d.speech = above;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign speech_o = state_q.speech;
    assign floor_o  = state_q.floor;

    logic unused_dir;
    assign unused_dir = ^step_dir;
endmodule

// File: rtl/nm_burst_monitor_chk.sv
module nm_burst_monitor_chk #(
    parameter int unsigned ENV_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick_i,
    input logic [ENV_W-1:0] env_i,
    input logic             speech_o,
    input logic [ENV_W-1:0] floor_o,
    input logic             primed
);
    AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(floor_o) && $stable(speech_o)); // R2

    AST_SEED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !primed) |=> !speech_o && floor_o == $past(env_i)); // R1

    AST_RISE_NO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && primed && env_i > floor_o) |=> floor_o > $past(floor_o) && floor_o <= $past(env_i)); // R9

    AST_FALL_NO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && primed && env_i < floor_o) |=> floor_o < $past(floor_o) && floor_o >= $past(env_i)); // R4

    AST_SPEECH_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> (speech_o |-> $past(env_i) > floor_o)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        !rst_ni |-> !speech_o && floor_o == '0); // R1
endmodule

bind nm_burst_monitor nm_burst_monitor_chk #(.ENV_W(ENV_W)) i_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .env_i   (env_i),
    .speech_o(speech_o),
    .floor_o (floor_o),
    .primed  (state_q.primed)
);

// File: tb/test_nm_burst_monitor.sv
`timescale 1ns/1ps
module test_nm_burst_monitor;
    localparam int W  = 8;
    localparam int KR = 4;
    localparam int KF = 1;

    logic         clk = 1'b0;
    logic         rst_ni = 1'b0;
    logic         tick = 1'b0;
    logic [W-1:0] env = '0;
    logic         speech;
    logic [W-1:0] flr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nm_burst_monitor #(.ENV_W(W), .K_RISE(KR), .K_FALL(KF)) i_nm_burst_monitor (
        .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .env_i(env),
        .speech_o(speech), .floor_o(flr)
    );

    function automatic int next_floor(int f, int e);
        int d;
        if (e > f) begin
            d = (e - f) >> KR;
            return f + ((d == 0) ? 1 : d);
        end else if (e < f) begin
            d = (f - e) >> KF;
            return f - ((d == 0) ? 1 : d);
        end
        return f;
    endfunction

    function automatic bit want_speech(int e, int nf);
        return (e * 128) > (nf * 203);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_ni = 1'b0; tick = 1'b0;
        @(negedge clk); rst_ni = 1'b1;
    endtask

    task automatic step(int e);
        @(negedge clk); env = W'(e); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nf;
        // R1 reset state and seeding
        @(negedge clk);
        check("R1 floor in reset", int'(flr), 0);
        check("R1 speech in reset", int'(speech), 0);
        do_reset();
        step(200);
        check("R1 seed floor", int'(flr), 200);
        check("R1 seed speech", int'(speech), 0);

        // R2 envelope changes without tick
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); env = W'(i * 41);
            @(negedge clk);
            check("R2 floor held", int'(flr), 200);
            check("R2 speech held", int'(speech), 0);
        end

        // R3 R4 R5 R6 sweep: every envelope against sixteen floors
        for (int f = 0; f < 256; f += 17) begin
            for (int e = 0; e < 256; e++) begin
                do_reset();
                step(f);
                step(e);
                nf = next_floor(f, e);
                if (e > f)      check("R3 rise", int'(flr), nf);
                else if (e < f) check("R4 fall", int'(flr), nf);
                else            check("R5 equal", int'(flr), nf);
                check("R6 ratio", int'(speech), int'(want_speech(e, nf)));
            end
        end

        // R7 unit-step ramp never flags
        do_reset();
        step(0);
        for (int e = 1; e < 256; e++) begin
            step(e);
            check("R7 ramp quiet", int'(speech), 0);
            check("R7 ramp floor", int'(flr), e);
        end

        // R8 burst from a settled floor
        do_reset();
        step(40);
        for (int i = 0; i < 5; i++) step(40);
        check("R8 settled", int'(speech), 0);
        step(100);
        check("R8 burst flag", int'(speech), 1);
        check("R8 burst floor", int'(flr), 43);
        // R4 fast fall back toward quiet level
        step(3);
        check("R4 fall after burst", int'(flr), 23);
        check("R9 no speech on fall", int'(speech), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule